// File: doc/BRIEF.md
# Register Rename Stage with Free-List Allocation

This block renames one instruction per cycle for a small out-of-order core. Every instruction that writes a general register receives a physical register taken from the head of a free-list FIFO, and the map table is updated so that later readers see the new name. Source operands are translated through the map as it stood before the current instruction. Each translated source carries a ready flag, so a dependent instruction can be issued later while independent ones keep flowing.

Each accepted allocation also reports the physical register that the destination was mapped to before. The core holds that value until the instruction retires, then hands it back through the retire port, which pushes it onto the tail of the free list. Writeback marks a physical register ready.

An instruction flagged as writing a control/status register acts as a barrier. Once it has been accepted, the stall output holds every younger instruction at rename until the retire port reports that the barrier instruction has completed. Nothing is flushed.

Top module: `reg_rename`

## Requirements
- R1: After reset the map is the identity: architectural register r reads as physical r, and is ready. The free list holds physical registers AREGS to PREGS-1 in ascending order.
- R2: An accepted request with a nonzero destination reports in `pd_old` the destination's mapping as it stood before. From the next cycle, sources naming that destination translate to the new `pd`.
- R3: Sources translate through the map as it stood before the current request's own update. This holds even when a source equals the destination.
- R4: A newly allocated physical register reads as not ready until a writeback names it. From the cycle after that writeback it reads as ready.
- R5: Architectural register 0 is never renamed. As a source it gives physical 0 and ready. As a destination it allocates nothing, never stalls for lack of registers, and gives `pd` = `pd_old` = 0.
- R6: Allocation is first-in first-out. A register returned through the retire port (when `ret_valid` and `ret_free_en` are both 1) is handed out only after every register already in the list. A register returned in a cycle is not available to a request in that same cycle.
- R7: `req_stall` is 1 whenever the request needs a register and the free list is empty. A stalled request changes no state.
- R8: From the cycle after a request with `req_csr` = 1 is accepted, `req_stall` stays 1. It drops in the cycle after a retire with `ret_valid` = 1 and `ret_csr` = 1.
- R9: No physical register is handed out while it is still live, meaning mapped or not yet returned.
- R10: A source whose physical register is named by `wb_valid`/`wb_preg` in the same cycle reads as ready in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Rename request present |
| req_csr | input | 1 | Request writes a control/status register (barrier) |
| req_src1 | input | AW | First source architectural register |
| req_src2 | input | AW | Second source architectural register |
| req_dst | input | AW | Destination architectural register |
| req_dst_en | input | 1 | Request writes `req_dst` |
| req_stall | output | 1 | Request is not accepted this cycle |
| ps1 | output | PW | Physical register of source 1 |
| ps1_rdy | output | 1 | Source 1 value is available |
| ps2 | output | PW | Physical register of source 2 |
| ps2_rdy | output | 1 | Source 2 value is available |
| pd | output | PW | Newly allocated destination physical register |
| pd_old | output | PW | Previous mapping of the destination |
| wb_valid | input | 1 | Writeback present |
| wb_preg | input | PW | Physical register written back |
| ret_valid | input | 1 | An instruction retires |
| ret_free_en | input | 1 | Retiring instruction returns a register |
| ret_free_preg | input | PW | Register returned to the free list |
| ret_csr | input | 1 | Retiring instruction is the barrier instruction |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a writeback of a physical register arrives while a request reads that register as a source. In the second, a retire returns a register while a request needs one and the list is empty. The bench provokes both on purpose. It expects the source to read ready at once, and it expects the request to stall that cycle and to receive the returned register in the next cycle. A long random stream over a few architectural registers then makes these collisions frequent, and a bench model of the map, ready bits and free queue judges every output in every cycle.

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int AREGS = 32,
  parameter int PREGS = 48,
  parameter int AW = $clog2(AREGS),
  parameter int PW = $clog2(PREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_csr,
  input  logic [AW-1:0] req_src1,
  input  logic [AW-1:0] req_src2,
  input  logic [AW-1:0] req_dst,
  input  logic          req_dst_en,
  output logic          req_stall,
  output logic [PW-1:0] ps1,
  output logic          ps1_rdy,
  output logic [PW-1:0] ps2,
  output logic          ps2_rdy,
  output logic [PW-1:0] pd,
  output logic [PW-1:0] pd_old,
  input  logic          wb_valid,
  input  logic [PW-1:0] wb_preg,
  input  logic          ret_valid,
  input  logic          ret_free_en,
  input  logic [PW-1:0] ret_free_preg,
  input  logic          ret_csr
);
  localparam int DEPTH = PREGS - AREGS;
  localparam int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [PW-1:0]    map_q [AREGS];
  logic [PW-1:0]    fl_q  [DEPTH];
  logic [PREGS-1:0] rdy_q;
  logic [PTRW-1:0]  head_q, tail_q;
  logic [CW-1:0]    cnt_q;
  logic             bar_q;

  function automatic logic [PTRW-1:0] step_ptr(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire alloc = req_dst_en && (req_dst != '0);
  wire fire  = req_valid && !req_stall;
  wire take  = fire && alloc;
  wire give  = ret_valid && ret_free_en;

  assign req_stall = bar_q || (alloc && (cnt_q == '0));

  assign ps1     = map_q[req_src1];
  assign ps2     = map_q[req_src2];
  assign ps1_rdy = (req_src1 == '0) || rdy_q[ps1] || (wb_valid && wb_preg == ps1);
  assign ps2_rdy = (req_src2 == '0) || rdy_q[ps2] || (wb_valid && wb_preg == ps2);
  assign pd      = take ? fl_q[head_q] : '0;
  assign pd_old  = take ? map_q[req_dst] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < AREGS; i++) map_q[i] <= PW'(i);
      for (int i = 0; i < DEPTH; i++) fl_q[i] <= PW'(AREGS + i);
      rdy_q  <= '1;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(DEPTH);
      bar_q  <= 1'b0;
    end else begin
      if (take) begin
        map_q[req_dst] <= fl_q[head_q];
        head_q         <= step_ptr(head_q);
      end
      if (give) begin
        fl_q[tail_q] <= ret_free_preg;
        tail_q       <= step_ptr(tail_q);
      end
      cnt_q <= cnt_q + CW'(give) - CW'(take);
      if (wb_valid) rdy_q[wb_preg] <= 1'b1;
      if (take) rdy_q[fl_q[head_q]] <= 1'b0;
      if (fire && req_csr) bar_q <= 1'b1;
      else if (ret_valid && ret_csr) bar_q <= 1'b0;
    end
  end
endmodule

module reg_rename_chk #(
  parameter int AREGS = 32,
  parameter int PREGS = 48,
  parameter int AW = $clog2(AREGS),
  parameter int PW = $clog2(PREGS),
  parameter int CW = $clog2(PREGS - AREGS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_csr,
  input logic [AW-1:0]    req_src1,
  input logic [AW-1:0]    req_dst,
  input logic             req_dst_en,
  input logic             req_stall,
  input logic [PW-1:0]    ps1,
  input logic             ps1_rdy,
  input logic [PW-1:0]    pd,
  input logic [PW-1:0]    pd_old,
  input logic             wb_valid,
  input logic [PW-1:0]    wb_preg,
  input logic [PREGS-1:0] rdy_q,
  input logic [CW-1:0]    cnt_q
);
  wire c_take = req_valid && !req_stall && req_dst_en && (req_dst != '0);

  assert_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    c_take |-> pd != pd_old);
  assert_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    c_take |=> !rdy_q[$past(pd)]);
  assert_wb_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(c_take && pd == wb_preg)) |=> rdy_q[$past(wb_preg)]);
  assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_src1 == '0) |-> (ps1 == '0 && ps1_rdy));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PREGS - AREGS));
  assert_csr_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_stall && req_csr) |=> req_stall);
  assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_preg == ps1) |-> ps1_rdy);
endmodule

bind reg_rename reg_rename_chk #(.AREGS(AREGS), .PREGS(PREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_csr(req_csr),
  .req_src1(req_src1), .req_dst(req_dst), .req_dst_en(req_dst_en),
  .req_stall(req_stall), .ps1(ps1), .ps1_rdy(ps1_rdy), .pd(pd),
  .pd_old(pd_old), .wb_valid(wb_valid), .wb_preg(wb_preg),
  .rdy_q(rdy_q), .cnt_q(cnt_q)
);

// File: tb/reg_rename_bench.sv
module reg_rename_bench;
  localparam int AREGS = 32;
  localparam int PREGS = 48;
  localparam int AW = $clog2(AREGS);
  localparam int PW = $clog2(PREGS);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_csr = 0, req_dst_en = 0;
  logic [AW-1:0] req_src1 = '0, req_src2 = '0, req_dst = '0;
  logic req_stall, ps1_rdy, ps2_rdy;
  logic [PW-1:0] ps1, ps2, pd, pd_old;
  logic wb_valid = 0, ret_valid = 0, ret_free_en = 0, ret_csr = 0;
  logic [PW-1:0] wb_preg = '0, ret_free_preg = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  int mmap [AREGS];
  bit mrdy [PREGS];
  bit infree [PREGS];
  int fq [$];
  int rq_old [$];
  bit rq_has [$];
  bit rq_csr [$];
  bit mbar;

  always #5 clk = ~clk;

  reg_rename #(.AREGS(AREGS), .PREGS(PREGS)) u_reg_rename (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_csr(req_csr),
    .req_src1(req_src1), .req_src2(req_src2), .req_dst(req_dst),
    .req_dst_en(req_dst_en), .req_stall(req_stall), .ps1(ps1),
    .ps1_rdy(ps1_rdy), .ps2(ps2), .ps2_rdy(ps2_rdy), .pd(pd),
    .pd_old(pd_old), .wb_valid(wb_valid), .wb_preg(wb_preg),
    .ret_valid(ret_valid), .ret_free_en(ret_free_en),
    .ret_free_preg(ret_free_preg), .ret_csr(ret_csr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic src_chk(input int s, input int p, input bit r, input bit wbv, input int wbp);
    int e;
    bit er;
    e  = mmap[s];
    er = (s == 0) || mrdy[e] || (wbv && wbp == e);
    chk(p == e, (s == 0) ? "R5" : "R3", p, e);
    chk(r == er, (s == 0) ? "R5" : ((wbv && wbp == e && !mrdy[e]) ? "R10" : "R4"), r, er);
  endtask

  task automatic cycle(input bit v, input bit c, input int s1, input int s2, input int d,
                       input bit den, input bit wbv, input int wbp, input bit dor);
    bit rv, rh, rc, alloc, es, fire;
    int ro, p;
    @(negedge clk);
    rv = dor && rq_old.size() > 0;
    rh = 0; rc = 0; ro = 0;
    if (rv) begin ro = rq_old[0]; rh = rq_has[0]; rc = rq_csr[0]; end
    req_valid = v; req_csr = c; req_src1 = AW'(s1); req_src2 = AW'(s2);
    req_dst = AW'(d); req_dst_en = den;
    wb_valid = wbv; wb_preg = PW'(wbp);
    ret_valid = rv; ret_free_en = rh; ret_free_preg = PW'(ro); ret_csr = rc;
    #1;
    alloc = den && d != 0;
    es = mbar || (alloc && fq.size() == 0);
    chk(req_stall == es, mbar ? "R8" : "R7", req_stall, es);
    src_chk(s1, ps1, ps1_rdy, wbv, wbp);
    src_chk(s2, ps2, ps2_rdy, wbv, wbp);
    fire = v && !es;
    if (fire && alloc) begin
      chk(pd == fq[0], "R6", pd, fq[0]);
      chk(pd_old == mmap[d], "R2", pd_old, mmap[d]);
      chk(infree[pd], "R9", 0, 1);
    end else if (fire && den) begin
      chk(pd == 0 && pd_old == 0, "R5", pd, 0);
    end
    @(posedge clk);
    if (rv) begin
      void'(rq_old.pop_front()); void'(rq_has.pop_front()); void'(rq_csr.pop_front());
    end
    if (rv && rh) begin fq.push_back(ro); infree[ro] = 1; end
    if (wbv) mrdy[wbp] = 1;
    if (fire && alloc) begin
      p = fq.pop_front();
      infree[p] = 0; mrdy[p] = 0;
      rq_old.push_back(mmap[d]); rq_has.push_back(1); rq_csr.push_back(c);
      mmap[d] = p;
    end else if (fire) begin
      rq_old.push_back(0); rq_has.push_back(0); rq_csr.push_back(c);
    end
    if (fire && c) mbar = 1;
    else if (rv && rc) mbar = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < AREGS; i++) mmap[i] = i;
    for (int i = 0; i < PREGS; i++) begin mrdy[i] = 1; infree[i] = (i >= AREGS); end
    for (int i = AREGS; i < PREGS; i++) fq.push_back(i);
    mbar = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: identity map and all ready after reset
    for (int r = 0; r < AREGS; r++) begin
      @(negedge clk);
      req_src1 = AW'(r); req_src2 = AW'(AREGS - 1 - r);
      #1;
      chk(ps1 == r && ps1_rdy, "R1", ps1, r);
      chk(ps2 == AREGS - 1 - r && ps2_rdy, "R1", ps2, AREGS - 1 - r);
    end

    // R1/R6: drain the free list in ascending order
    for (int i = 1; i <= PREGS - AREGS; i++) cycle(1, 0, i, 0, i, 1, 0, 0, 0);
    // R7: empty list stalls, R5: dst 0 still proceeds
    cycle(1, 0, 1, 2, 5, 1, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 1, 0, 0, 0);
    // R10 + R6: same-cycle writeback bypass, returned reg not usable same cycle
    cycle(1, 0, 1, 0, 7, 1, 1, AREGS, 1);
    // R4 + R6: ready from table, returned register now allocated
    cycle(1, 0, 1, 0, 7, 1, 0, 0, 0);
    // R3: source equals destination reads the old mapping
    cycle(1, 0, 2, 2, 2, 1, 0, 0, 1);
    cycle(1, 0, 2, 2, 2, 1, 0, 0, 0);
    // R8: barrier holds until the barrier instruction retires
    cycle(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cycle(1, 0, 3, 0, 3, 1, 0, 0, 0);
    cycle(1, 0, 3, 0, 3, 1, 0, 0, 0);
    while (rq_old.size() > 0) cycle(1, 0, 3, 4, 3, 1, 0, 0, 1);
    cycle(1, 0, 3, 4, 3, 1, 0, 0, 0);

    // random streams over few registers: R2..R10 against the model
    for (int n = 0; n < 4000; n++) begin
      cycle($urandom_range(0, 9) < 8, $urandom_range(0, 31) == 0,
            $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, PREGS - 1), $urandom_range(0, 2) != 0);
    end
    finish_run();
  end
endmodule